// File: doc/BRIEF.md
# LED Blink and Beep Tone Generator

This block turns a set of small rate codes into visible and audible signalling. Each of several LED pins can blink at one of three slow rates with an even on/off split. A beeper pin can play a carrier tone that is switched on and off by a slower gate. For one beeper code the tone does not go silent but swaps between two pitches. A code of zero hands a pin back to its ordinary general-purpose output value. The integration logic then sees no difference from a plain output pin.

All timing comes from the one input clock. A free-running prescaler divides it down to a fixed base tick of `BASE_HZ`, which is 8 kHz by default. Each pin keeps its own half-period counter in units of that tick. Whenever a pin's code changes, that pin restarts from its low level, so the new rate begins with a full clean half-period. A low-power input freezes the prescaler and every counter, and each drive output holds the level it had.

Top module: `led_beep_gen`

## Requirements
- R1: An LED code of 2'b11 blinks at 2 Hz, 2'b10 at 1 Hz and 2'b01 at 0.5 Hz. Each of these has 50% duty, so the level holds for BASE_HZ/4, BASE_HZ/2 or BASE_HZ base ticks before it toggles.
- R2: LED pin i is controlled only by `led_cfg[2*i+1:2*i]`. Pin 0 uses bits 1:0, and the last pin uses the top two bits.
- R3: When an LED code is 2'b00, `led_drive[i]` equals `gpio_led[i]` in the same cycle, including when `gpio_led` changes.
- R4: When any LED or beep code changes to a non-zero value, that pin's drive is low from the edge that sees the new code. For an LED, the first high level comes one full half-period later.
- R5: Beep code 2'b11 plays a 4 kHz carrier gated at 250 Hz. The tone sounds for 2 ms, is silent for 2 ms, and starts in the sounding phase.
- R6: Beep code 2'b10 plays a 2 kHz carrier gated at 10 Hz: 50 ms sounding, then 50 ms silent.
- R7: Beep code 2'b01 never goes silent. It plays 1 kHz for 0.5 s, then 500 Hz for 0.5 s, and repeats.
- R8: When the beep code is 2'b00, `beep_drive` equals `gpio_beep` in the same cycle.
- R9: While `low_power` is high and the codes and GPIO inputs are held, every drive output keeps its level.
- R10: During and right after reset, all special-function levels are low, so every pin shows its GPIO value or low.
- R11: `func_active[i]` is high for LED i when its code is non-zero, and the top bit is high when the beep code is non-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock of CLK_HZ |
| rst_n | input | 1 | Active-low synchronous reset |
| led_cfg | input | 2*LEDS | Packed 2-bit rate codes, pin 0 in the lowest bits |
| beep_cfg | input | 2 | Beeper tone code |
| low_power | input | 1 | Freezes all timebases and outputs |
| gpio_led | input | LEDS | Fallback GPIO output values for the LED pins |
| gpio_beep | input | 1 | Fallback GPIO output value for the beeper pin |
| led_drive | output | LEDS | Drive value for each LED pin |
| beep_drive | output | 1 | Drive value for the beeper pin |
| func_active | output | LEDS+1 | Special function selected per pin, beeper in the top bit |

## Verification
The bound checker watches four things on every cycle:
- the same-cycle GPIO fallback for every pin whose code is zero;
- the forced low level on the edge where a code changes;
- the frozen outputs while low power is held;
- the LED blink half-period, which it checks with a counter.

Only the bench scenarios can show the actual blink rates and their 50% duty, the carrier pitch and gate pattern of each beep code, and the swap between the two pitches in the alternating mode. The bench shows these through level samples taken mid-half-period and through counts of rising edges over a window, compared against figures worked out from the base-tick arithmetic.

// File: rtl/led_beep_pkg.sv
package led_beep_pkg;

   typedef enum logic [1:0] {
      RATE_NONE = 2'b00,
      RATE_SLOW = 2'b01,
      RATE_MID  = 2'b10,
      RATE_FAST = 2'b11
   } rate_code_e;

   // Half-period of an LED blink, counted in base ticks
   function automatic int unsigned blink_half(input logic [1:0] code,
                                              input int unsigned base_hz);
      case (rate_code_e'(code))
         RATE_FAST: return base_hz / 4;
         RATE_MID:  return base_hz / 2;
         RATE_SLOW: return base_hz;
         default:   return 1;
      endcase
   endfunction

endpackage

// File: rtl/tone_prescaler.sv
module tone_prescaler #(
   parameter int unsigned DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   output logic tick_o
);
   generate
      if (DIV == 1) begin : g_pass
         // Base rate equals clock: every running cycle is a tick
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign tick_o = !hold;
      end else begin : g_cnt
         localparam int unsigned W = $clog2(DIV);
         logic [W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (!hold)
               cnt_q <= (cnt_q == W'(DIV - 1)) ? '0 : cnt_q + 1'b1;
         end
         assign tick_o = !hold && (cnt_q == W'(DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/blink_lane.sv
module blink_lane
   import led_beep_pkg::*;
#(
   parameter int unsigned BASE_HZ = 8000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic [1:0] code,
   output logic       level_o
);
   localparam int unsigned CW = $clog2(BASE_HZ + 1);

   logic [1:0]    prev_q;
   logic [CW-1:0] cnt_q;
   logic          lvl_q;
   logic [CW-1:0] half_len;

   assign half_len = CW'(blink_half(code, BASE_HZ));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= 2'b00;
         cnt_q  <= '0;
         lvl_q  <= 1'b0;
      end else if (code != prev_q) begin
         // New rate: restart from low with a full half-period
         prev_q <= code;
         cnt_q  <= '0;
         lvl_q  <= 1'b0;
      end else if (tick && code != 2'b00) begin
         if (cnt_q == half_len - 1'b1) begin
            cnt_q <= '0;
            lvl_q <= ~lvl_q;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign level_o = (code == prev_q) && lvl_q;
endmodule

// File: rtl/beep_tone.sv
module beep_tone #(
   parameter int unsigned BASE_HZ = 8000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic [1:0] code,
   output logic       tone_o
);
   localparam int unsigned CW     = $clog2(BASE_HZ + 1);
   localparam int unsigned CAR_4K = BASE_HZ / 8000;
   localparam int unsigned CAR_2K = BASE_HZ / 4000;
   localparam int unsigned CAR_1K = BASE_HZ / 2000;
   localparam int unsigned CAR_LO = BASE_HZ / 1000;
   localparam int unsigned GT_FST = BASE_HZ / 500;
   localparam int unsigned GT_MID = BASE_HZ / 20;
   localparam int unsigned GT_ALT = BASE_HZ / 2;

   logic [1:0]    prev_q;
   logic [CW-1:0] gate_cnt_q;
   logic          gate_ph_q;   // 0: first phase (sounding / higher pitch)
   logic [CW-1:0] car_cnt_q;
   logic          car_lvl_q;
   logic [CW-1:0] gate_len;
   logic [CW-1:0] car_len;

   always_comb begin
      case (code)
         2'b11:   begin gate_len = CW'(GT_FST); car_len = CW'(CAR_4K); end
         2'b10:   begin gate_len = CW'(GT_MID); car_len = CW'(CAR_2K); end
         2'b01:   begin
                     gate_len = CW'(GT_ALT);
                     car_len  = gate_ph_q ? CW'(CAR_LO) : CW'(CAR_1K);
                  end
         default: begin gate_len = CW'(1); car_len = CW'(1); end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q     <= 2'b00;
         gate_cnt_q <= '0;
         gate_ph_q  <= 1'b0;
         car_cnt_q  <= '0;
         car_lvl_q  <= 1'b0;
      end else if (code != prev_q) begin
         prev_q     <= code;
         gate_cnt_q <= '0;
         gate_ph_q  <= 1'b0;
         car_cnt_q  <= '0;
         car_lvl_q  <= 1'b0;
      end else if (tick && code != 2'b00) begin
         if (gate_cnt_q == gate_len - 1'b1) begin
            // Phase boundary: carrier restarts clean
            gate_cnt_q <= '0;
            gate_ph_q  <= ~gate_ph_q;
            car_cnt_q  <= '0;
            car_lvl_q  <= 1'b0;
         end else begin
            gate_cnt_q <= gate_cnt_q + 1'b1;
            if (car_cnt_q == car_len - 1'b1) begin
               car_cnt_q <= '0;
               car_lvl_q <= ~car_lvl_q;
            end else begin
               car_cnt_q <= car_cnt_q + 1'b1;
            end
         end
      end
   end

   assign tone_o = (code == prev_q) && (code != 2'b00) && car_lvl_q
                   && (code == 2'b01 || !gate_ph_q);
endmodule

// File: rtl/led_beep_gen.sv
module led_beep_gen #(
   parameter int unsigned CLK_HZ  = 32_000_000,
   parameter int unsigned BASE_HZ = 8000,
   parameter int unsigned LEDS    = 4
) (
   input  logic [0:0]      clk,
   input  logic            rst_n,
   input  logic [2*LEDS-1:0] led_cfg,
   input  logic [1:0]      beep_cfg,
   input  logic            low_power,
   input  logic [LEDS-1:0] gpio_led,
   input  logic            gpio_beep,
   output logic [LEDS-1:0] led_drive,
   output logic            beep_drive,
   output logic [LEDS:0]   func_active
);
   localparam int unsigned DIV = CLK_HZ / BASE_HZ;

   generate
      if (CLK_HZ < BASE_HZ || (CLK_HZ % BASE_HZ) != 0) begin : g_bad_clk
         $error("CLK_HZ must be a whole multiple of BASE_HZ");
      end
      if ((BASE_HZ % 8000) != 0) begin : g_bad_base
         $error("BASE_HZ must be a multiple of 8000");
      end
      if (LEDS < 1) begin : g_bad_leds
         $error("LEDS must be at least 1");
      end
   endgenerate

   logic tick;
   logic tone;

   tone_prescaler #(.DIV(DIV)) u_presc (
      .clk    (clk),
      .rst_n  (rst_n),
      .hold   (low_power),
      .tick_o (tick)
   );

   for (genvar i = 0; i < LEDS; i++) begin : g_lane
      logic lvl;
      blink_lane #(.BASE_HZ(BASE_HZ)) u_lane (
         .clk     (clk),
         .rst_n   (rst_n),
         .tick    (tick),
         .code    (led_cfg[2*i +: 2]),
         .level_o (lvl)
      );
      assign func_active[i] = |led_cfg[2*i +: 2];
      assign led_drive[i]   = func_active[i] ? lvl : gpio_led[i];
   end

   beep_tone #(.BASE_HZ(BASE_HZ)) u_beep (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .code   (beep_cfg),
      .tone_o (tone)
   );

   assign func_active[LEDS] = |beep_cfg;
   assign beep_drive        = func_active[LEDS] ? tone : gpio_beep;
endmodule

// File: rtl/led_beep_chk.sv
module led_beep_chk #(
   parameter int unsigned CLK_HZ  = 32_000_000,
   parameter int unsigned BASE_HZ = 8000,
   parameter int unsigned LEDS    = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2*LEDS-1:0] led_cfg,
   input logic [1:0]        beep_cfg,
   input logic              low_power,
   input logic [LEDS-1:0]   gpio_led,
   input logic              gpio_beep,
   input logic [LEDS-1:0]   led_drive,
   input logic              beep_drive
);
   localparam int unsigned FAST_CYC = (CLK_HZ / BASE_HZ) * (BASE_HZ / 4);
   localparam int unsigned RW       = $clog2(FAST_CYC + 2);

   for (genvar i = 0; i < LEDS; i++) begin : g_pin
      assert_led_fallback_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (led_cfg[2*i +: 2] == 2'b00) |-> (led_drive[i] == gpio_led[i]));

      assert_led_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (led_cfg[2*i +: 2] != $past(led_cfg[2*i +: 2]) && led_cfg[2*i +: 2] != 2'b00)
         |-> !led_drive[i]);

      // Cycles the pin has held its level under an unchanged non-zero code
      logic [RW-1:0] run_q;
      always_ff @(posedge clk) begin
         if (!rst_n || led_cfg[2*i +: 2] == 2'b00 || led_cfg[2*i +: 2] != $past(led_cfg[2*i +: 2]))
            run_q <= '0;
         else if (led_drive[i] != $past(led_drive[i]))
            run_q <= RW'(1);
         else if (!low_power && run_q != {RW{1'b1}})
            run_q <= run_q + 1'b1;
      end

      // R1: no half-period is shorter than the fastest blink allows
      assert_led_min_half_R1: assert property (@(posedge clk) disable iff (!rst_n)
         (led_cfg[2*i +: 2] != 2'b00 && $stable(led_cfg[2*i +: 2]) && !low_power
          && led_drive[i] != $past(led_drive[i]))
         |-> (run_q >= RW'(FAST_CYC - 2)));
   end

   assert_beep_fallback_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (beep_cfg == 2'b00) |-> (beep_drive == gpio_beep));

   assert_beep_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (beep_cfg != $past(beep_cfg) && beep_cfg != 2'b00) |-> !beep_drive);

   assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (low_power && $past(low_power) && $stable(led_cfg) && $stable(beep_cfg)
       && $stable(gpio_led) && $stable(gpio_beep))
      |-> ($stable(led_drive) && $stable(beep_drive)));
endmodule

bind led_beep_gen led_beep_chk #(.CLK_HZ(CLK_HZ), .BASE_HZ(BASE_HZ), .LEDS(LEDS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .led_cfg    (led_cfg),
   .beep_cfg   (beep_cfg),
   .low_power  (low_power),
   .gpio_led   (gpio_led),
   .gpio_beep  (gpio_beep),
   .led_drive  (led_drive),
   .beep_drive (beep_drive)
);

// File: tb/tb_led_beep_gen.sv
module tb_led_beep_gen;
   localparam int unsigned CLK_HZ  = 16000;  // scaled: two clocks per base tick
   localparam int unsigned BASE_HZ = 8000;
   localparam int unsigned LEDS    = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] led_cfg = 8'h00;
   logic [1:0] beep_cfg = 2'b00;
   logic       low_power = 1'b0;
   logic [3:0] gpio_led = 4'b1010;
   logic       gpio_beep = 1'b1;
   logic [3:0] led_drive;
   logic       beep_drive;
   logic [4:0] func_active;

   always #4 clk = ~clk;

   led_beep_gen #(.CLK_HZ(CLK_HZ), .BASE_HZ(BASE_HZ), .LEDS(LEDS)) dut (
      .clk(clk), .rst_n(rst_n), .led_cfg(led_cfg), .beep_cfg(beep_cfg),
      .low_power(low_power), .gpio_led(gpio_led), .gpio_beep(gpio_beep),
      .led_drive(led_drive), .beep_drive(beep_drive), .func_active(func_active)
   );

   typedef struct {
      int         at;
      int         kind;   // 0 drive {beep,led}, 1 func_active, 2 rise count
      logic [4:0] mask;
      logic [4:0] exp;
      int         base;
      int         lo;
      int         hi;
      string      req;
   } item_t;

   item_t q[$];
   int cyc = 0;
   int rise_cnt = 0;
   logic beep_prev = 1'b0;
   int checks = 0;
   int fails = 0;
   bit done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   // Monitor: count beeper rises, pop and compare due items
   always @(negedge clk) begin
      if (rst_n) begin
         if (beep_drive && !beep_prev) rise_cnt = rise_cnt + 1;
         beep_prev = beep_drive;
      end
      while (q.size() > 0 && q[0].at <= cyc) begin
         item_t it;
         it = q.pop_front();
         checks++;
         if (it.kind == 0) begin
            if ((({beep_drive, led_drive}) & it.mask) !== (it.exp & it.mask)) begin
               fails++;
               $display("FAIL %s drive: actual %b expected %b (mask %b) cycle %0d",
                        it.req, {beep_drive, led_drive}, it.exp, it.mask, cyc);
            end
         end else if (it.kind == 1) begin
            if (func_active !== it.exp) begin
               fails++;
               $display("FAIL %s func_active: actual %b expected %b", it.req, func_active, it.exp);
            end
         end else begin
            if ((rise_cnt - it.base) < it.lo || (rise_cnt - it.base) > it.hi) begin
               fails++;
               $display("FAIL %s beep rises: actual %0d expected %0d..%0d",
                        it.req, rise_cnt - it.base, it.lo, it.hi);
            end
         end
      end
   end

   task automatic push_drive(input int at, input logic [4:0] mask, input logic [4:0] exp,
                             input string req);
      item_t it;
      it.at = at; it.kind = 0; it.mask = mask; it.exp = exp;
      it.base = 0; it.lo = 0; it.hi = 0; it.req = req;
      q.push_back(it);
   endtask

   task automatic push_flag(input int at, input logic [4:0] exp, input string req);
      item_t it;
      it.at = at; it.kind = 1; it.mask = 5'h1f; it.exp = exp;
      it.base = 0; it.lo = 0; it.hi = 0; it.req = req;
      q.push_back(it);
   endtask

   task automatic push_rises(input int at, input int lo, input int hi, input string req);
      item_t it;
      it.at = at; it.kind = 2; it.mask = 0; it.exp = 0;
      it.base = rise_cnt; it.lo = lo; it.hi = hi; it.req = req;
      q.push_back(it);
   endtask

   task automatic wait_until(input int c);
      while (cyc < c) @(posedge clk);
      #1;
   endtask

   // Apply codes just after an edge; returns the cycle that captures them
   task automatic apply(input logic [7:0] lc, input logic [1:0] bc, output int p1);
      @(posedge clk); #1;
      led_cfg = lc; beep_cfg = bc;
      p1 = cyc + 1;
   endtask

   initial begin
      int p;
      int t;
      repeat (4) @(posedge clk);
      #1;
      // R10: reset state, all pins on their GPIO values
      push_drive(cyc, 5'h1f, 5'b11010, "R10");
      push_flag(cyc, 5'b00000, "R10");
      rst_n = 1'b1;
      push_drive(cyc + 2, 5'h1f, 5'b11010, "R10");
      wait_until(cyc + 3);

      // R1/R2/R3/R11: LED0 2 Hz, LED1 1 Hz, LED2 0.5 Hz, LED3 GPIO
      apply(8'b00_01_10_11, 2'b00, p);
      push_flag(p + 2, 5'b00111, "R11");
      push_drive(p + 2000,  5'b01111, 5'b01000, "R1");
      push_drive(p + 6000,  5'b01111, 5'b01001, "R1");
      push_drive(p + 10000, 5'b01111, 5'b01010, "R2");
      push_drive(p + 14000, 5'b01111, 5'b01011, "R1");
      push_drive(p + 18000, 5'b01111, 5'b01100, "R2");
      push_drive(p + 22000, 5'b00001, 5'b00001, "R1");
      wait_until(p + 22001);

      // R4: LED0 switches 2 Hz -> 1 Hz while high
      apply(8'b00_01_10_10, 2'b00, p);
      push_drive(p,         5'b00001, 5'b00000, "R4");
      push_drive(p + 4000,  5'b00001, 5'b00000, "R4");
      push_drive(p + 12000, 5'b00001, 5'b00001, "R4");
      wait_until(p + 12001);

      // R9: low power freezes a high LED
      apply(8'b00_01_10_11, 2'b00, p);
      push_drive(p + 6000, 5'b00001, 5'b00001, "R9");
      wait_until(p + 6500);
      low_power = 1'b1;
      t = cyc;
      push_drive(t + 2000, 5'b00001, 5'b00001, "R9");
      push_drive(t + 9000, 5'b00001, 5'b00001, "R9");
      wait_until(t + 9001);
      low_power = 1'b0;

      // R2/R3/R11: only the last pin blinks, the rest follow GPIO
      gpio_led = 4'b0101;
      apply(8'b11_00_00_00, 2'b00, p);
      push_flag(p + 2, 5'b01000, "R11");
      push_drive(p + 2000, 5'b01111, 5'b00101, "R2");
      push_drive(p + 6000, 5'b01111, 5'b01101, "R2");
      wait_until(p + 6500);
      gpio_led = 4'b0010;
      push_drive(p + 6501, 5'b01111, 5'b01010, "R3");
      wait_until(p + 6600);

      // R5: 4 kHz carrier, 250 Hz gate -> 8 rises per 64 cycles
      apply(8'b11_00_00_00, 2'b11, p);
      push_flag(p + 2, 5'b11000, "R11");
      push_rises(p + 640, 78, 82, "R5");
      wait_until(p + 641);

      // R6: 2 kHz carrier, 10 Hz gate
      apply(8'b11_00_00_00, 2'b10, p);
      wait_until(p + 810);
      push_rises(p + 1590, 0, 0, "R6");
      wait_until(p + 1600);
      push_rises(p + 4800, 198, 202, "R6");
      wait_until(p + 4801);

      // R7: 1 kHz for half a second, then 500 Hz
      apply(8'b11_00_00_00, 2'b01, p);
      wait_until(p + 10);
      push_rises(p + 7990, 497, 501, "R7");
      wait_until(p + 8010);
      push_rises(p + 15990, 247, 251, "R7");
      wait_until(p + 15991);

      // R8: beep code zero falls back to GPIO
      apply(8'b11_00_00_00, 2'b00, p);
      gpio_beep = 1'b1;
      push_drive(p + 1, 5'b10000, 5'b10000, "R8");
      push_flag(p + 1, 5'b01000, "R11");
      wait_until(p + 3);
      gpio_beep = 1'b0;
      push_drive(cyc, 5'b10000, 5'b00000, "R8");
      wait_until(cyc + 3);

      if (!done) begin
         done = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule